// File: doc/BRIEF.md
# Flash Chip-Erase Command Decoder and Erase Engine

This block sits in front of a small on-chip NOR-style word array and watches the host's bus write cycles for one command: a chip erase. The erase is accepted only when six writes arrive back to back in a fixed unlock, setup, unlock, command order. After that the block runs its own erase algorithm with no further help from the host. The algorithm first writes zero to every word and checks each word for zero. It then writes all ones to every word.

While the algorithm runs, the ready output is low. A host read returns a status word instead of array data, and two of its bits flip on every read. When the algorithm ends, the block goes back to reading the array directly. Bus writes are ignored while the algorithm runs. Pulling the hardware reset low stops the algorithm at once. The host must then send the whole six-write sequence again.

Top module: `flash_erase_ctrl`

## Requirements
- R1: Six writes in this order start an erase: data 0xAA at address 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, then 0x10 at 0x555 (full 12-bit address compare). `ready_o` is low from the clock edge that accepts the sixth write.
- R2: A write whose address or data differs from the one expected next sends the decoder back to its first step. A broken sequence never starts an erase, and a correct sequence written right after a broken one starts an erase normally.
- R3: After the start, the engine stays busy for exactly 3*DEPTH clock cycles (preprogram, verify and erase, one word per clock each). `ready_o` is high again after the last erase step.
- R4: When an uninterrupted erase completes, every word reads 0xFF and `err_o` is low. `err_o` is cleared at each erase start and is set if any word fails the all-zero verify.
- R5: Writes made while busy are ignored. They do not restart or lengthen the erase, and they leave no partial sequence behind: after completion the decoder starts again from its first step.
- R6: A read while busy returns a status word: bit 7 = 0, bits 6 and 2 both carry a toggle bit, all other bits 0. The toggle bit is 0 after reset and flips after every busy read.
- R7: A read while idle returns, one clock after the read edge, the array word indexed by the low log2(DEPTH) address bits. `bus_rdata` holds its value on cycles with no read.
- R8: An active-low `rst_n` pulse during an erase stops it at once (`ready_o` high asynchronously). Words already processed keep their new value and the others are untouched. A partial sequence written before the reset counts for nothing afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset, released synchronously inside |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_re | input | 1 | Host read strobe, one cycle per read |
| bus_addr | input | AW (12) | Host address |
| bus_wdata | input | DW (8) | Host write data |
| bus_rdata | output | DW (8) | Registered read data: array word or busy status |
| ready_o | output | 1 | High when idle, low while the erase algorithm runs |
| err_o | output | 1 | Verify-failure flag of the latest erase |

## Verification
A decoder stuck in a middle step shows up when a broken sequence starts an erase. The reverse fault also shows: a correct sequence written after a mismatch or after a busy period fails to start one, and `ready_o` diverges within a clock of the sixth write. A phase or word counter that is off by one changes the busy length, and the bench sees this on `ready_o` at the exact cycle of completion. It also shows later as a word that does not read 0xFF, or one that differs from the reference after a reset abort. A wrong toggle register shows on the very next busy read, because the reference tracks every read since reset.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam int unsigned UNLOCK_ADDR_A = 32'h555;
  localparam int unsigned UNLOCK_ADDR_B = 32'h2AA;
  localparam int unsigned UNLOCK_DATA_A = 32'hAA;
  localparam int unsigned UNLOCK_DATA_B = 32'h55;
  localparam int unsigned SETUP_DATA    = 32'h80;
  localparam int unsigned CHIP_ERASE_DATA = 32'h10;

  localparam int unsigned POLL_BIT   = 7;
  localparam int unsigned TOGGLE_BIT = 6;
  localparam int unsigned ALT_TOGGLE_BIT = 2;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_KEY1  = 3'd1,
    SQ_KEY2  = 3'd2,
    SQ_ARMED = 3'd3,
    SQ_KEY3  = 3'd4,
    SQ_KEY4  = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ZERO   = 2'd1,
    PH_CHECK  = 2'd2,
    PH_ERASE  = 2'd3
  } phase_e;

endpackage

// File: rtl/fe_rst_sync.sv
module fe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/fe_cmd_seq.sv
module fe_cmd_seq
  import flash_erase_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  output logic          start,
  output seq_state_e    state
);

  seq_state_e    state_q, state_n;
  logic [AW-1:0] exp_addr;
  logic [DW-1:0] exp_data;
  logic          hit;

  // expected write for the current step
  always_comb begin
    exp_addr = AW'(UNLOCK_ADDR_A);
    exp_data = DW'(UNLOCK_DATA_A);
    case (state_q)
      SQ_IDLE:  begin exp_addr = AW'(UNLOCK_ADDR_A); exp_data = DW'(UNLOCK_DATA_A); end
      SQ_KEY1:  begin exp_addr = AW'(UNLOCK_ADDR_B); exp_data = DW'(UNLOCK_DATA_B); end
      SQ_KEY2:  begin exp_addr = AW'(UNLOCK_ADDR_A); exp_data = DW'(SETUP_DATA);    end
      SQ_ARMED: begin exp_addr = AW'(UNLOCK_ADDR_A); exp_data = DW'(UNLOCK_DATA_A); end
      SQ_KEY3:  begin exp_addr = AW'(UNLOCK_ADDR_B); exp_data = DW'(UNLOCK_DATA_B); end
      SQ_KEY4:  begin exp_addr = AW'(UNLOCK_ADDR_A); exp_data = DW'(CHIP_ERASE_DATA); end
      default:  begin exp_addr = AW'(UNLOCK_ADDR_A); exp_data = DW'(UNLOCK_DATA_A); end
    endcase
  end

  assign hit = (wr_addr == exp_addr) && (wr_data == exp_data);

  // next-state
  always_comb begin
    state_n = state_q;
    start   = 1'b0;
    if (busy) begin
      state_n = SQ_IDLE;
    end else if (wr_en) begin
      if (!hit) begin
        state_n = SQ_IDLE;
      end else begin
        case (state_q)
          SQ_IDLE:  state_n = SQ_KEY1;
          SQ_KEY1:  state_n = SQ_KEY2;
          SQ_KEY2:  state_n = SQ_ARMED;
          SQ_ARMED: state_n = SQ_KEY3;
          SQ_KEY3:  state_n = SQ_KEY4;
          SQ_KEY4: begin
            state_n = SQ_IDLE;
            start   = 1'b1;
          end
          default:  state_n = SQ_IDLE;
        endcase
      end
    end
  end

  // register
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= SQ_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/fe_erase_engine.sv
module fe_erase_engine
  import flash_erase_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          start,
  input  logic [DW-1:0] chk_word,
  output logic [IW-1:0] idx,
  output logic          arr_we,
  output logic [DW-1:0] arr_wdata,
  output logic          busy,
  output logic          err
);

  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

  phase_e        phase_q, phase_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          err_q, err_n;
  logic          at_last;

  assign at_last = (idx_q == LAST_IDX);

  // next-state
  always_comb begin
    phase_n   = phase_q;
    idx_n     = idx_q;
    err_n     = err_q;
    arr_we    = 1'b0;
    arr_wdata = '0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_n = PH_ZERO;
          idx_n   = '0;
          err_n   = 1'b0;
        end
      end
      PH_ZERO: begin
        arr_we    = 1'b1;
        arr_wdata = '0;
        idx_n     = at_last ? '0 : idx_q + 1'b1;
        if (at_last) phase_n = PH_CHECK;
      end
      PH_CHECK: begin
        if (chk_word != '0) err_n = 1'b1;
        idx_n = at_last ? '0 : idx_q + 1'b1;
        if (at_last) phase_n = PH_ERASE;
      end
      PH_ERASE: begin
        arr_we    = 1'b1;
        arr_wdata = '1;
        idx_n     = at_last ? '0 : idx_q + 1'b1;
        if (at_last) phase_n = PH_IDLE;
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_n;
      idx_q   <= idx_n;
      err_q   <= err_n;
    end
  end

  assign idx  = idx_q;
  assign busy = (phase_q != PH_IDLE);
  assign err  = err_q;

endmodule

// File: rtl/fe_word_array.sv
module fe_word_array #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx_a,
  output logic [DW-1:0] rdata_a,
  input  logic [IW-1:0] ridx_b,
  output logic [DW-1:0] rdata_b
);

  // non-volatile contents: deliberately not cleared by reset
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[widx] <= wdata;
    end
  end

  assign rdata_a = cells[ridx_a];
  assign rdata_b = cells[ridx_b];

endmodule

// File: rtl/fe_read_port.sv
module fe_read_port
  import flash_erase_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          rd_en,
  input  logic          busy,
  input  logic [DW-1:0] arr_word,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] rdata_q, rdata_n;
  logic          tog_q, tog_n;
  logic [DW-1:0] status_word;

  always_comb begin
    status_word                 = '0;
    status_word[POLL_BIT]       = 1'b0;
    status_word[TOGGLE_BIT]     = tog_q;
    status_word[ALT_TOGGLE_BIT] = tog_q;
  end

  // next-state
  always_comb begin
    rdata_n = rdata_q;
    tog_n   = tog_q;
    if (rd_en) begin
      if (busy) begin
        rdata_n = status_word;
        tog_n   = ~tog_q;
      end else begin
        rdata_n = arr_word;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdata_q <= '0;
      tog_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_n;
      tog_q   <= tog_n;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int unsigned AW    = 12,
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          ready_o,
  output logic          err_o
);

  logic          srst_n;
  logic          start;
  seq_state_e    seq_state;
  logic          busy;
  logic [IW-1:0] eng_idx;
  logic          arr_we;
  logic [DW-1:0] arr_wdata;
  logic [DW-1:0] chk_word;
  logic [DW-1:0] host_word;

  fe_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  fe_cmd_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk     (clk),
    .srst_n  (srst_n),
    .wr_en   (bus_we),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .busy    (busy),
    .start   (start),
    .state   (seq_state)
  );

  fe_erase_engine #(.DEPTH(DEPTH), .DW(DW)) u_eng (
    .clk       (clk),
    .srst_n    (srst_n),
    .start     (start),
    .chk_word  (chk_word),
    .idx       (eng_idx),
    .arr_we    (arr_we),
    .arr_wdata (arr_wdata),
    .busy      (busy),
    .err       (err_o)
  );

  fe_word_array #(.DEPTH(DEPTH), .DW(DW)) u_arr (
    .clk     (clk),
    .we      (arr_we),
    .widx    (eng_idx),
    .wdata   (arr_wdata),
    .ridx_a  (eng_idx),
    .rdata_a (chk_word),
    .ridx_b  (bus_addr[IW-1:0]),
    .rdata_b (host_word)
  );

  fe_read_port #(.DW(DW)) u_rd (
    .clk      (clk),
    .srst_n   (srst_n),
    .rd_en    (bus_re),
    .busy     (busy),
    .arr_word (host_word),
    .rdata    (bus_rdata)
  );

  assign ready_o = ~busy;

endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk
  import flash_erase_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          bus_re,
  input  logic [DW-1:0] bus_rdata,
  input  logic          ready_o,
  input  logic          start,
  input  logic          arr_we,
  input  seq_state_e    seq_state
);

  // R1: an accepted sixth write makes the block busy on the next cycle
  a_r1_start_drops_ready: assert property (@(posedge clk) disable iff (!srst_n)
    start |=> !ready_o);

  // R5: no sequence progress is held while busy
  a_r5_seq_rest_while_busy: assert property (@(posedge clk) disable iff (!srst_n)
    !ready_o |-> (seq_state == SQ_IDLE));

  // R3: the array is only written by the running algorithm
  a_r3_array_write_when_busy: assert property (@(posedge clk) disable iff (!srst_n)
    arr_we |-> !ready_o);

  // R6: polling bit reads zero during the erase
  a_r6_poll_bit_low: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_re && !ready_o) |=> !bus_rdata[POLL_BIT]);

  // R6: both toggle bits carry the same value
  a_r6_toggle_pair: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_re && !ready_o) |=> (bus_rdata[TOGGLE_BIT] == bus_rdata[ALT_TOGGLE_BIT]));

  // R7: read data holds without a read strobe
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !bus_re |=> $stable(bus_rdata));

endmodule

bind flash_erase_ctrl flash_erase_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .srst_n    (srst_n),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .ready_o   (ready_o),
  .start     (start),
  .arr_we    (arr_we),
  .seq_state (seq_state)
);

// File: tb/flash_erase_ctrl_tb_top.sv
module flash_erase_ctrl_tb_top;

  localparam int AW    = 12;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int BUSY_LEN = 3 * DEPTH;

  logic          clk;
  logic          rst_n;
  logic          bus_we;
  logic          bus_re;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          ready_o;
  logic          err_o;

  int checks;
  int failures;
  bit done;

  flash_erase_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ready_o   (ready_o),
    .err_o     (err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  int  m_cnt;          // busy cycles still to run
  int  m_stage;        // sequence progress 0..5
  bit  m_tog;
  int  m_mem   [DEPTH];
  bit  m_known [DEPTH];
  int  seq_a [6] = '{32'h555, 32'h2AA, 32'h555, 32'h555, 32'h2AA, 32'h555};
  int  seq_d [6] = '{32'hAA,  32'h55,  32'h80,  32'hAA,  32'h55,  32'h10};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock with the given strobes; model steps with the pre-edge state
  task automatic cyc(input bit w, input bit r, input int a, input int d, input string req);
    int exp_rd;
    bit rd_valid;
    int k;
    @(negedge clk);
    bus_we = w; bus_re = r; bus_addr = AW'(a); bus_wdata = DW'(d);
    @(posedge clk);
    #1;
    rd_valid = 1'b0;
    exp_rd = 0;
    if (r) begin
      if (m_cnt > 0) begin
        exp_rd = (int'(m_tog) << 6) | (int'(m_tog) << 2);
        m_tog = ~m_tog;
        rd_valid = 1'b1;
      end else begin
        exp_rd = m_mem[a % DEPTH];
        rd_valid = m_known[a % DEPTH];
      end
    end
    if (m_cnt > 0) begin
      k = BUSY_LEN - m_cnt;
      if (k < DEPTH) begin
        m_mem[k] = 0; m_known[k] = 1'b1;
      end else if (k >= 2 * DEPTH) begin
        m_mem[k - 2 * DEPTH] = 32'hFF; m_known[k - 2 * DEPTH] = 1'b1;
      end
      m_cnt--;
    end else if (w) begin
      if (a == seq_a[m_stage] && d == seq_d[m_stage]) begin
        if (m_stage == 5) begin
          m_stage = 0;
          m_cnt = BUSY_LEN;
        end else begin
          m_stage++;
        end
      end else begin
        m_stage = 0;
      end
    end
    bus_we = 1'b0; bus_re = 1'b0;
    check(ready_o == (m_cnt == 0), {req, " ready_o (R3)"}, int'(ready_o), int'(m_cnt == 0));
    check(err_o == 1'b0, "R4 err_o", int'(err_o), 0);
    if (rd_valid) check(int'(bus_rdata) == exp_rd, {req, " read data"}, int'(bus_rdata), exp_rd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 0, 0, "R3");
  endtask

  task automatic send_seq(input string req);
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, seq_a[i], seq_d[i], req);
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < DEPTH; i++) cyc(1'b0, 1'b1, i, 0, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_cnt = 0; m_stage = 0; m_tog = 1'b0;
    #2;
    check(ready_o == 1'b1, "R8 ready_o during reset", int'(ready_o), 1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // watchdog
  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int first;
    checks = 0; failures = 0; done = 1'b0;
    bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < DEPTH; i++) begin m_mem[i] = 0; m_known[i] = 1'b0; end
    m_cnt = 0; m_stage = 0; m_tog = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(ready_o == 1'b1, "R3 reset ready_o", int'(ready_o), 1);
    check(err_o == 1'b0, "R4 reset err_o", int'(err_o), 0);
    check(bus_rdata == '0, "R7 reset rdata", int'(bus_rdata), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1: full sequence starts the erase; R6: busy reads toggle
    send_seq("R1");
    cyc(1'b0, 1'b1, 0, 0, "R6");
    first = int'(bus_rdata[6]);
    cyc(1'b0, 1'b1, 0, 0, "R6");
    check(int'(bus_rdata[6]) != first, "R6 toggle flips", int'(bus_rdata[6]), 1 - first);
    cyc(1'b0, 1'b1, 3, 0, "R6");
    // R5: a full sequence written while busy is ignored
    send_seq("R5");
    while (m_cnt > 0) cyc(1'b0, 1'b0, 0, 0, "R3");
    idle(2);
    read_all("R4");
    read_all("R7");

    // R2: broken sequences, wrong data then wrong address
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, seq_a[i], seq_d[i], "R2");
    cyc(1'b1, 1'b0, 32'h555, 32'h30, "R2");
    idle(3);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, seq_a[i], seq_d[i], "R2");
    cyc(1'b1, 1'b0, 32'h556, 32'h10, "R2");
    cyc(1'b1, 1'b0, 32'h2AA, 32'h55, "R2");
    idle(3);
    // R2: correct sequence right after a mismatch still starts
    send_seq("R2");
    check(ready_o == 1'b0, "R2 restart after mismatch", int'(ready_o), 0);

    // R5: partial sequence during busy leaves nothing behind
    cyc(1'b1, 1'b0, 32'h555, 32'hAA, "R5");
    cyc(1'b1, 1'b0, 32'h2AA, 32'h55, "R5");
    while (m_cnt > 0) cyc(1'b0, 1'b0, 0, 0, "R3");
    for (int i = 2; i < 6; i++) cyc(1'b1, 1'b0, seq_a[i], seq_d[i], "R5");
    idle(3);
    check(ready_o == 1'b1, "R5 no start from leftover", int'(ready_o), 1);

    // R8: reset during erase phase, three words already erased
    send_seq("R8");
    for (int i = 0; i < 2 * DEPTH + 3; i++) cyc(1'b0, 1'b0, 0, 0, "R8");
    do_reset();
    idle(3);
    read_all("R8");
    check(m_mem[2] == 32'hFF && m_mem[3] == 0, "R8 model split", m_mem[3], 0);

    // R8: partial sequence before reset counts for nothing
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, seq_a[i], seq_d[i], "R8");
    do_reset();
    idle(3);
    for (int i = 3; i < 6; i++) cyc(1'b1, 1'b0, seq_a[i], seq_d[i], "R8");
    idle(2);
    check(ready_o == 1'b1, "R8 no start after reset", int'(ready_o), 1);

    // R8: full sequence after reset completes normally
    send_seq("R8");
    while (m_cnt > 0) cyc(1'b0, 1'b0, 0, 0, "R3");
    idle(1);
    read_all("R4");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule